// File: doc/BRIEF.md
# Load-Store Alignment and Byte-Lane Unit

This unit sits between a 32-bit core and a word-wide data memory. For each load or store request it takes a byte address, an access width (byte, halfword or word), a signedness flag, the byte-order setting and the store data. It checks alignment and traps misaligned halfword and word accesses with a fault. A faulting request never reaches memory. A legal request produces the word address, a four-bit byte-lane enable mask and the store data shifted onto its lanes.

Load data comes back from a synchronous memory one cycle after the request. The unit keeps the offset, width, signedness and byte order of the accepted load for that cycle. When the memory word arrives, it selects the addressed bytes, reorders them and extends them to 32 bits. Byte order is a per-request input, so software can switch it between any two accesses. Memory lane k always holds byte address (word address + k).

Top module: `lsu_lane_unit`

## Requirements
- R1: A byte access (size_i = 2'b00) never faults, at any address.
- R2: A halfword access (size_i = 2'b01) at an odd address raises misalign_o in the same cycle. It also holds mem_req_o, mem_we_o and mem_be_o at zero.
- R3: A word access (size_i = 2'b10) whose two low address bits are not 00 faults and is blocked in the same way. Size code 2'b11 is reserved and always faults.
- R4: mem_addr_o equals addr_i with bits [1:0] cleared.
- R5: mem_be_o is 4'b0001 << addr_i[1:0] for a byte and 4'b0011 << addr_i[1:0] for a halfword. It is 4'b1111 for a word. It is zero when there is no request or the request faults.
- R6: Little-endian store (big_endian_i = 0): data byte j (j = 0 is least significant) is driven on lane addr_i[1:0] + j of mem_wdata_o. Disabled lanes read zero.
- R7: Big-endian store (big_endian_i = 1): with n bytes in the access, data byte j is driven on lane addr_i[1:0] + n - 1 - j.
- R8: Little-endian load: result byte j is taken from lane addr_i[1:0] + j of the memory word.
- R9: Big-endian load: result byte j is taken from lane addr_i[1:0] + n - 1 - j.
- R10: Byte and halfword loads fill the upper result bits with copies of the loaded value's top bit when signed_i = 1, and with zeros when signed_i = 0.
- R11: rvalid_o is high for exactly the one cycle that follows an accepted load. It stays low after stores, faulting requests and idle cycles.
- R12: The width, offset, signedness and byte order of a load are captured at request time. A different request or a new byte order in the following cycle does not change the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| signed_i | input | 1 | Sign-extend narrow loads |
| big_endian_i | input | 1 | Byte order for this access |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store value, right-aligned |
| mem_rdata_i | input | 32 | Memory read word, one cycle after request |
| misalign_o | output | 1 | Misalignment fault |
| mem_req_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-placed store data |
| rdata_o | output | 32 | Extended load result |
| rvalid_o | output | 1 | Load result valid |

## Verification
Load return and request decode share a cycle. A load's data appears while the next request is already on the inputs and being checked for alignment and lanes. The bench drives requests back to back. It puts a store, a faulting access or a flipped byte order straight after a load, and it mixes all of these in a long random stream. A behavioural byte-array model predicts the outputs. Each cycle the lanes and fault of the current request are compared, and so is the returned value of the previous load, which must follow that load's own width and byte order.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic             req_i,
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             fault_o,
  output logic [OFF_W-1:0] nb_m1_o,
  output logic [LANES-1:0] be_o
);
  logic             misal;
  logic [LANES-1:0] base_mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin misal = 1'b0;          nb_m1_o = '0;             base_mask = LANES'(1); end
      SZ_HALF: begin misal = off_i[0];      nb_m1_o = OFF_W'(1);      base_mask = LANES'(3); end
      SZ_WORD: begin misal = (off_i != '0); nb_m1_o = OFF_W'(LANES-1); base_mask = '1;       end
      default: begin misal = 1'b1;          nb_m1_o = '0;             base_mask = '0;        end
    endcase
  end

  assign fault_o = req_i & misal;
  assign be_o    = (req_i && !misal) ? (base_mask << off_i) : '0;
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    wdata_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] nb_m1_i,
  input  logic             big_i,
  input  logic [LANES-1:0] be_i,
  output logic [DW-1:0]    lanes_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFF_W-1:0] KK = OFF_W'(k);
    logic [OFF_W-1:0] src;
    // data byte feeding lane k; only meaningful when the lane is enabled
    assign src = big_i ? (off_i + nb_m1_i - KK) : (KK - off_i);
    assign lanes_o[k*8 +: 8] = be_i[k] ? wdata_i[{src, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    rdata_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] nb_m1_i,
  input  logic             big_i,
  input  logic             sgn_i,
  output logic [DW-1:0]    data_o
);
  logic [7:0] raw [LANES];
  logic       fill;

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    localparam logic [OFF_W-1:0] JJ = OFF_W'(j);
    logic [OFF_W-1:0] lane;
    assign lane    = big_i ? (off_i + nb_m1_i - JJ) : (off_i + JJ);
    assign raw[j]  = rdata_i[{lane, 3'b000} +: 8];
    assign data_o[j*8 +: 8] = (JJ <= nb_m1_i) ? raw[j] : {8{fill}};
  end

  assign fill = sgn_i & raw[nb_m1_i][7];
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int AW = 32,
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic             signed_i,
  input  logic             big_endian_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             misalign_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [LANES-1:0] mem_be_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic [OFF_W-1:0] off, nb_m1;
  logic             fault, accept;

  // pending load context for the data-return cycle
  logic             ld_vld_q, ld_big_q, ld_sgn_q;
  logic [OFF_W-1:0] ld_off_q, ld_nbm1_q;

  assign off = addr_i[OFF_W-1:0];

  lsu_align_chk #(.LANES(LANES)) u_align (
    .req_i  (req_i),
    .size_i (acc_size_e'(size_i)),
    .off_i  (off),
    .fault_o(fault),
    .nb_m1_o(nb_m1),
    .be_o   (mem_be_o)
  );

  lsu_store_lanes #(.LANES(LANES)) u_store (
    .wdata_i(wdata_i),
    .off_i  (off),
    .nb_m1_i(nb_m1),
    .big_i  (big_endian_i),
    .be_i   (mem_be_o),
    .lanes_o(mem_wdata_o)
  );

  assign accept     = req_i & ~fault;
  assign misalign_o = fault;
  assign mem_req_o  = accept;
  assign mem_we_o   = accept & we_i;
  assign mem_addr_o = {addr_i[AW-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_vld_q  <= 1'b0;
      ld_big_q  <= 1'b0;
      ld_sgn_q  <= 1'b0;
      ld_off_q  <= '0;
      ld_nbm1_q <= '0;
    end else begin
      ld_vld_q <= accept & ~we_i;
      if (accept && !we_i) begin
        ld_big_q  <= big_endian_i;
        ld_sgn_q  <= signed_i;
        ld_off_q  <= off;
        ld_nbm1_q <= nb_m1;
      end
    end
  end

  lsu_load_extract #(.LANES(LANES)) u_load (
    .rdata_i(mem_rdata_i),
    .off_i  (ld_off_q),
    .nb_m1_i(ld_nbm1_q),
    .big_i  (ld_big_q),
    .sgn_i  (ld_sgn_q),
    .data_o (rdata_o)
  );

  assign rvalid_o = ld_vld_q;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] size_i,
  input logic [1:0] addr_lo,
  input logic       misalign_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [1:0] mem_addr_lo,
  input logic [3:0] mem_be_o,
  input logic       rvalid_o
);
  AST_BYTE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i == 2'b00 |-> !misalign_o && mem_req_o); // R1
  AST_HALF_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i == 2'b01 && addr_lo[0] |-> misalign_o && !mem_req_o && !mem_we_o); // R2
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i == 2'b10 && addr_lo != 2'b00 |-> misalign_o && mem_be_o == 4'h0); // R3
  AST_ADDR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_lo == 2'b00); // R4
  AST_BE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && size_i == 2'b10 |-> mem_be_o == 4'hf); // R5
  AST_BE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && size_i == 2'b01 |-> $countones(mem_be_o) == 2); // R5
  AST_BE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> mem_be_o == 4'h0); // R5
  AST_RVALID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !we_i |=> rvalid_o); // R11
  AST_RVALID_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o || we_i |=> !rvalid_o); // R11
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .size_i     (size_i),
  .addr_lo    (addr_i[1:0]),
  .misalign_o (misalign_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_lo(mem_addr_o[1:0]),
  .mem_be_o   (mem_be_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sgn = 1'b0, big = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] addr = '0, wdata = '0, mem_rdata = '0;
  logic        misalign, mem_req, mem_we, rvalid;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic [3:0]  mem_be;

  int n_tests = 0, n_fail = 0;
  logic [7:0] mem_b [64];
  logic [7:0] ref_b [64];

  // pending expectation for the data-return cycle
  logic        pend_vld = 1'b0;
  logic [31:0] pend_data = '0;
  string       pend_tag = "R8";
  string       tag_ovr = "";

  always #5ns clk = ~clk;

  lsu_lane_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .signed_i(sgn), .big_endian_i(big), .addr_i(addr), .wdata_i(wdata),
    .mem_rdata_i(mem_rdata), .misalign_o(misalign), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // synchronous word memory, lane k = byte address base + k
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem_b[mem_addr[5:0] + 6'(k)] <= mem_wdata[k*8 +: 8];
      end else begin
        for (int k = 0; k < 4; k++)
          mem_rdata[k*8 +: 8] <= mem_b[mem_addr[5:0] + 6'(k)];
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic check_return();
    chk(rvalid === pend_vld, "R11", 32'(rvalid), 32'(pend_vld));
    if (pend_vld) chk(rdata === pend_data, pend_tag, rdata, pend_data);
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0;
    #1;
    check_return();
    chk(mem_req === 1'b0 && mem_be === 4'h0, "R5", {27'b0, mem_req, mem_be}, 32'h0);
    pend_vld = 1'b0;
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input bit s, input bit b,
                        input logic [31:0] a, input logic [31:0] d);
    int n, off;
    bit flt;
    logic [3:0]  exp_be;
    logic [31:0] val;
    string       rt;
    @(negedge clk);
    req = 1'b1; we = w; size = sz; sgn = s; big = b; addr = a; wdata = d;
    #1;
    check_return();
    n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    off = int'(a[1:0]);
    flt = (sz == 2'b11) || (off % n != 0);
    rt  = (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : "R3";
    chk(misalign === flt, rt, 32'(misalign), 32'(flt));
    chk(mem_req === !flt && mem_we === (!flt && w), rt, {30'b0, mem_req, mem_we}, {30'b0, !flt, !flt && w});
    exp_be = flt ? 4'h0 : 4'(((1 << n) - 1) << off);
    chk(mem_be === exp_be, "R5", 32'(mem_be), 32'(exp_be));
    chk(mem_addr === {a[31:2], 2'b00}, "R4", mem_addr, {a[31:2], 2'b00});
    pend_vld = 1'b0;
    if (!flt) begin
      val = '0;
      for (int j = 0; j < n; j++) begin
        int ba = int'(a[5:0]) + (b ? n - 1 - j : j);
        int ln = ba % 4;
        if (w) begin
          chk(mem_wdata[ln*8 +: 8] === d[j*8 +: 8], b ? "R7" : "R6",
              32'(mem_wdata[ln*8 +: 8]), 32'(d[j*8 +: 8]));
          ref_b[ba] = d[j*8 +: 8];
        end else begin
          val[j*8 +: 8] = ref_b[ba];
        end
      end
      if (!w) begin
        if (n < 4 && s && val[n*8-1]) for (int j = n; j < 4; j++) val[j*8 +: 8] = 8'hff;
        pend_vld  = 1'b1;
        pend_data = val;
        pend_tag  = (tag_ovr != "") ? tag_ovr : (n < 4) ? "R10" : (b ? "R9" : "R8");
      end
    end
  endtask

  initial begin
    #(1_000_000ns);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem_b[i] = 8'h00; ref_b[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(rvalid === 1'b0 && mem_req === 1'b0 && mem_be === 4'h0, "R11",
        {30'b0, rvalid, mem_req}, 32'h0);
    rst_n = 1'b1;
    // fill memory with little-endian words
    for (int i = 0; i < 16; i++) access(1, 2'b10, 0, 0, 32'(i*4), 32'h8070_6050 + 32'(i * 32'h0101_0101));
    // R8 little loads at each width
    access(0, 2'b10, 0, 0, 32'h8, 0);
    access(0, 2'b00, 0, 0, 32'h9, 0);
    access(0, 2'b01, 0, 0, 32'h6, 0);
    // R9 big-endian reads of the same bytes
    access(0, 2'b10, 0, 1, 32'hc, 0);
    access(0, 2'b01, 0, 1, 32'he, 0);
    // R10 signed and unsigned narrow loads of a negative byte/halfword
    access(1, 2'b01, 0, 0, 32'h20, 32'h0000_9c81);
    access(0, 2'b00, 1, 0, 32'h20, 0);
    access(0, 2'b00, 0, 0, 32'h20, 0);
    access(0, 2'b01, 1, 0, 32'h20, 0);
    access(0, 2'b01, 0, 1, 32'h20, 0);
    access(0, 2'b01, 1, 1, 32'h20, 0);
    // R7 big-endian stores, read back both ways
    access(1, 2'b10, 0, 1, 32'h30, 32'h1122_3344);
    access(0, 2'b10, 0, 0, 32'h30, 0);
    access(1, 2'b01, 0, 1, 32'h36, 32'h0000_a5b6);
    access(0, 2'b00, 0, 0, 32'h36, 0);
    access(1, 2'b00, 0, 1, 32'h3b, 32'h0000_00e7);
    access(0, 2'b10, 0, 0, 32'h38, 0);
    // R2/R3 faults: blocked, no return, memory untouched
    access(0, 2'b01, 0, 0, 32'h11, 0);
    access(1, 2'b01, 0, 0, 32'h13, 32'hdead_beef);
    access(1, 2'b10, 0, 0, 32'h15, 32'hdead_beef);
    access(1, 2'b10, 0, 1, 32'h16, 32'hdead_beef);
    access(0, 2'b10, 0, 0, 32'h17, 0);
    access(1, 2'b11, 0, 0, 32'h10, 32'hdead_beef);
    access(0, 2'b10, 0, 0, 32'h10, 0);
    access(0, 2'b10, 0, 0, 32'h14, 0);
    idle();
    // R12 load followed at once by other requests with flipped order
    tag_ovr = "R12";
    access(0, 2'b01, 1, 1, 32'h32, 0);
    access(1, 2'b00, 0, 0, 32'h32, 32'h0000_0077);
    access(0, 2'b00, 1, 0, 32'h33, 0);
    access(0, 2'b10, 0, 1, 32'h11, 0);
    access(0, 2'b10, 0, 1, 32'h30, 0);
    access(0, 2'b01, 0, 0, 32'h30, 0);
    idle();
    tag_ovr = "";
    // mixed random stream
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else access($urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom_range(0, 1),
                  $urandom_range(0, 1), 32'($urandom_range(0, 63)), $urandom);
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule